// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that a processor drives through a small 32-bit register bus made of write and read strobes, a word address and a data word. Software pushes bytes into a 16-entry transmit queue. The engine shifts each byte out on MOSI and at the same time captures one byte from MISO into a 16-entry receive queue. Software then collects the received bytes by reading the receive data register.

The control register sets the serial clock idle level, the sampling edge, the bit order and internal loopback. It also gates the engine with an enable, a master-mode bit and an inhibit bit, and chooses between software-held and automatic slave selects. Each queue can be flushed from the control register. A software reset register returns the whole block to its reset state, but only when the written word matches a fixed key. An interrupt output reports completed bytes and a drained transmit queue.

The serial clock runs at the system clock divided by 2*CLK_DIV. The transfer width is fixed at 8 bits.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, the registers read as follows: control reads 0x180 (inhibit and manual select set), status reads 0x05, slave select reads all ones, and both occupancy registers read 0. The outputs sclk, ss_n and irq sit at 0, all ones and 0.
- R2: Word addresses are 7 global irq enable (bit 31), 8 irq status, 10 irq enable, 16 software reset, 24 control, 25 status, 26 TX data, 27 RX data, 28 slave select, 29 TX occupancy and 30 RX occupancy. Read data appears on bus_rdata one cycle after bus_rd.
- R3: A TX data write queues bits 7:0 only. The TX queue holds 16 bytes, a write to a full queue is dropped, and TX occupancy reads the number of queued bytes.
- R4: A byte starts only when control bits 1 (enable) and 2 (master) are set, bit 8 (inhibit) is clear and the TX queue is not empty. Every byte shifted out pushes exactly one received byte into the RX queue.
- R5: Setting inhibit lets the byte in progress complete, then keeps the bus idle with the queued bytes left in place.
- R6: An RX data read returns the oldest byte in bits 7:0 with zeros above. A read of an empty queue returns 0. A byte that arrives while the RX queue is full is discarded.
- R7: Control bit 3 gives the SCLK idle level. When control bit 4 is 0, data is sampled on the first edge of each bit; when it is 1, data is sampled on the second edge.
- R8: With control bit 9 set, bits go out and come in least significant first; otherwise most significant first.
- R9: With control bit 0 set, the receive side samples MOSI instead of MISO.
- R10: With control bit 7 set, ss_n follows the slave select register. With it clear, ss_n carries that register only while a byte is in flight and is all ones otherwise.
- R11: Writing control bit 5 flushes the TX queue and writing bit 6 flushes the RX queue. Both bits read back as 0.
- R12: Writing 0x0A to the software reset register restores every register and queue to its R1 state. Any other value has no effect.
- R13: Irq status bit 0 sets when a byte completes. Bit 1 sets when the last queued TX byte is taken. Writing 1 to a bit clears it. irq is high when global enable bit 31 is set and any status bit is set that is also enabled.
- R14: Status bit 0 is RX empty, bit 1 RX full, bit 2 TX empty and bit 3 TX full. Bits 4 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The assertions take certain bus behaviour for granted. Bus strobes last one cycle. The slave select register is not rewritten in the middle of a byte when its value is expected on ss_n. The clock idle level is changed only while no device is selected. The stimulus respects these limits: every bus access is a single-cycle task, the selects are deselected before the control register is reprogrammed, and the bench waits for the receive count before reading. Random rounds draw the mode, bit order, loopback, select style and byte values from a fixed seed. Directed cases cover the full queues, the inhibit, the flushes, the reset key and the interrupt path.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  // word addresses
  localparam int unsigned A_GIE   = 7;
  localparam int unsigned A_ISR   = 8;
  localparam int unsigned A_IER   = 10;
  localparam int unsigned A_SRR   = 16;
  localparam int unsigned A_CR    = 24;
  localparam int unsigned A_SR    = 25;
  localparam int unsigned A_TXD   = 26;
  localparam int unsigned A_RXD   = 27;
  localparam int unsigned A_SSR   = 28;
  localparam int unsigned A_TXOCC = 29;
  localparam int unsigned A_RXOCC = 30;

  // control bit positions
  localparam int unsigned CB_LOOP  = 0;
  localparam int unsigned CB_EN    = 1;
  localparam int unsigned CB_MAST  = 2;
  localparam int unsigned CB_CPOL  = 3;
  localparam int unsigned CB_CPHA  = 4;
  localparam int unsigned CB_TXRST = 5;
  localparam int unsigned CB_RXRST = 6;
  localparam int unsigned CB_MANSS = 7;
  localparam int unsigned CB_INHIB = 8;
  localparam int unsigned CB_LSB   = 9;

  localparam logic [9:0]  CR_RESET = 10'h180;
  localparam logic [31:0] SRR_KEY  = 32'h0000_000A;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
    logic loopb;
  } spi_mode_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   dout,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           empty,
  output logic                           full
);
  localparam int unsigned AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (cnt == CW'(DEPTH))); // R3
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R11
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_regs_pkg::*;
#(
  parameter int unsigned DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  spi_mode_t  mode_i,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int unsigned DW = (DIV < 2) ? 1 : $clog2(DIV);

  logic          busy_q, done_q, sclk_q, mosi_q;
  logic [DW-1:0] div_cnt;
  logic [4:0]    edge_cnt;
  logic [7:0]    tx_sr, rx_sr, rx_q;
  spi_mode_t     mode_q;
  logic          lead, sample_edge, rx_in, drive_ok;

  function automatic logic first_bit(input logic [7:0] b, input logic lsb);
    return lsb ? b[0] : b[7];
  endfunction

  function automatic logic [7:0] adv(input logic [7:0] b, input logic lsb);
    return lsb ? {1'b0, b[7:1]} : {b[6:0], 1'b0};
  endfunction

  assign lead        = ~edge_cnt[0];
  assign sample_edge = lead ^ mode_q.cpha;
  assign rx_in       = mode_q.loopb ? mosi_q : miso;
  assign drive_ok    = mode_q.cpha || (edge_cnt != 5'd15);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_q     <= '0;
      mode_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= mode_i.cpol;
        if (start) begin
          busy_q   <= 1'b1;
          mode_q   <= mode_i;
          div_cnt  <= '0;
          edge_cnt <= '0;
          rx_sr    <= '0;
          if (!mode_i.cpha) begin
            mosi_q <= first_bit(tx_byte, mode_i.lsb);
            tx_sr  <= adv(tx_byte, mode_i.lsb);
          end else begin
            tx_sr  <= tx_byte;
          end
        end
      end else if (div_cnt == DW'(DIV-1)) begin
        div_cnt <= '0;
        if (edge_cnt == 5'd16) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= rx_sr;
        end else begin
          sclk_q   <= ~sclk_q;
          edge_cnt <= edge_cnt + 5'd1;
          if (sample_edge) begin
            rx_sr <= mode_q.lsb ? {rx_in, rx_sr[7:1]} : {rx_sr[6:0], rx_in};
          end else if (drive_ok) begin
            mosi_q <= first_bit(tx_sr, mode_q.lsb);
            tx_sr  <= adv(tx_sr, mode_q.lsb);
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= 5'd16); // R7
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q) && $stable(mode_i.cpol)) |-> (sclk_q == mode_i.cpol)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q); // R4
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned NUM_SS     = 32,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned CLK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH+1);

  logic [9:0]        cr_q;
  logic [NUM_SS-1:0] ssr_q, ss_q;
  logic              gie_q, irq_q;
  logic [1:0]        ier_q, isr_q, isr_set;
  logic [31:0]       rdata_q;

  logic soft_rst, core_rst;
  logic wr_cr, wr_txd, rd_rxd;
  logic tx_clr, rx_clr, start;
  logic [7:0] tx_dout, rx_dout, shf_rx;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic shf_busy, shf_done;
  spi_mode_t mode;

  assign soft_rst = bus_wr && (bus_addr == ADDR_W'(A_SRR)) && (bus_wdata == SRR_KEY);
  assign core_rst = rst || soft_rst;
  assign wr_cr    = bus_wr && (bus_addr == ADDR_W'(A_CR));
  assign wr_txd   = bus_wr && (bus_addr == ADDR_W'(A_TXD));
  assign rd_rxd   = bus_rd && (bus_addr == ADDR_W'(A_RXD));
  assign tx_clr   = wr_cr && bus_wdata[CB_TXRST];
  assign rx_clr   = wr_cr && bus_wdata[CB_RXRST];

  assign start = cr_q[CB_EN] && cr_q[CB_MAST] && !cr_q[CB_INHIB] && !tx_empty && !shf_busy;

  assign mode.cpol  = cr_q[CB_CPOL];
  assign mode.cpha  = cr_q[CB_CPHA];
  assign mode.lsb   = cr_q[CB_LSB];
  assign mode.loopb = cr_q[CB_LOOP];

  spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(core_rst), .clr(tx_clr),
    .push(wr_txd), .din(bus_wdata[7:0]),
    .pop(start), .dout(tx_dout),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(core_rst), .clr(rx_clr),
    .push(shf_done), .din(shf_rx),
    .pop(rd_rxd), .dout(rx_dout),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  spi_shifter #(.DIV(CLK_DIV)) u_shf (
    .clk(clk), .rst(core_rst), .start(start), .tx_byte(tx_dout),
    .mode_i(mode), .miso(miso), .sclk(sclk), .mosi(mosi),
    .busy(shf_busy), .done(shf_done), .rx_byte(shf_rx)
  );

  assign isr_set = {start && (tx_cnt == CW'(1)), shf_done};

  // register file
  always_ff @(posedge clk) begin
    if (core_rst) begin
      cr_q  <= CR_RESET;
      ssr_q <= '1;
      gie_q <= 1'b0;
      ier_q <= '0;
      isr_q <= '0;
    end else begin
      if (wr_cr) cr_q <= bus_wdata[9:0] & ~10'h060;
      if (bus_wr && bus_addr == ADDR_W'(A_SSR)) ssr_q <= bus_wdata[NUM_SS-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_GIE)) gie_q <= bus_wdata[31];
      if (bus_wr && bus_addr == ADDR_W'(A_IER)) ier_q <= bus_wdata[1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_ISR))
        isr_q <= (isr_q & ~bus_wdata[1:0]) | isr_set;
      else
        isr_q <= isr_q | isr_set;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (core_rst) begin
      ss_q    <= '1;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ss_q  <= (cr_q[CB_MANSS] || start || shf_busy) ? ssr_q : '1;
      irq_q <= gie_q && |(isr_q & ier_q);
      if (bus_rd) begin
        case (bus_addr)
          ADDR_W'(A_GIE):   rdata_q <= {gie_q, 31'd0};
          ADDR_W'(A_ISR):   rdata_q <= {30'd0, isr_q};
          ADDR_W'(A_IER):   rdata_q <= {30'd0, ier_q};
          ADDR_W'(A_CR):    rdata_q <= {22'd0, cr_q};
          ADDR_W'(A_SR):    rdata_q <= {28'd0, tx_full, tx_empty, rx_full, rx_empty};
          ADDR_W'(A_RXD):   rdata_q <= rx_empty ? 32'd0 : {24'd0, rx_dout};
          ADDR_W'(A_SSR):   rdata_q <= 32'(ssr_q);
          ADDR_W'(A_TXOCC): rdata_q <= 32'(tx_cnt);
          ADDR_W'(A_RXOCC): rdata_q <= 32'(rx_cnt);
          default:          rdata_q <= 32'd0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign ss_n      = ss_q;

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cr_q[CB_INHIB] && !shf_busy) |=> !shf_busy); // R5
  AST_START_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(shf_busy) |-> $past(cr_q[CB_EN] && cr_q[CB_MAST] && !cr_q[CB_INHIB])); // R4
  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_rxd && rx_empty) |=> (bus_rdata == 32'd0)); // R6
  AST_SOFT_RST: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cr_q == CR_RESET && ssr_q == '1)); // R12
  AST_SS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (shf_busy && $past(shf_busy) && $stable(ssr_q)) |-> (ss_n == ssr_q)); // R10
  AST_SS_MANUAL: assert property (@(posedge clk) disable iff (rst)
    (cr_q[CB_MANSS] && $past(cr_q[CB_MANSS]) && $stable(ssr_q)) |-> (ss_n == ssr_q)); // R10
endmodule

// File: tb/sim_spi_master_regs.sv
module sim_spi_master_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NSS = 32;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, sclk, mosi, miso;
  logic [NSS-1:0] ss_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench-side model state
  logic m_cpol = 0, m_cpha = 0, m_lsb = 0;
  logic [7:0] mon_exp [64];
  logic [7:0] slv_q [64];
  int mon_wp = 0, mon_rp = 0;
  logic [3:0] bi = 0;
  logic [7:0] cap = 0;
  logic sclk_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_master_regs #(.ADDR_W(5), .NUM_SS(NSS), .FIFO_DEPTH(16), .CLK_DIV(2)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  assign miso = m_lsb ? slv_q[mon_rp[5:0]][bi[2:0]] : slv_q[mon_rp[5:0]][3'd7 - bi[2:0]];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sr(input int txc, input int rxc);
    return {28'd0, txc == 16, txc == 0, rxc == 16, rxc == 0};
  endfunction

  function automatic logic [31:0] mk_cr(input logic lb, input logic cpol, input logic cpha,
                                        input logic man, input logic inh, input logic lsb);
    return 32'h6 | 32'(lb) | (32'(cpol) << 3) | (32'(cpha) << 4) | (32'(man) << 7)
         | (32'(inh) << 8) | (32'(lsb) << 9);
  endfunction

  // serial-side monitor and slave model: sample MOSI and advance MISO on sample edges
  always @(negedge clk) begin
    if (&ss_n) begin
      bi = 0;
      cap = 0;
    end else if (sclk != sclk_prev) begin
      if ((sclk != m_cpol) ^ m_cpha) begin
        cap = m_lsb ? {mosi, cap[7:1]} : {cap[6:0], mosi};
        bi = bi + 1;
        if (bi == 8) begin
          check("R7/R8 mosi byte", {24'd0, cap}, {24'd0, mon_exp[mon_rp[5:0]]});
          mon_rp++;
          bi = 0;
          cap = 0;
        end
      end
    end
    sclk_prev = sclk;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = 5'(a);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic push_tx(input logic [7:0] b, input logic [7:0] s);
    mon_exp[mon_wp[5:0]] = b;
    slv_q[mon_wp[5:0]] = s;
    mon_wp++;
    wr(26, {$urandom, b} >> 0 & 32'hFFFF_FF00 | 32'(b));
  endtask

  task automatic reset_mon();
    mon_wp = 0; mon_rp = 0;
  endtask

  task automatic wait_rx(input int n);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(30, v);
      if (v == 32'(n)) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0] txb [16];
    logic [7:0] slb [16];
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(24, v); check("R1 cr", v, 32'h180);
    rd(25, v); check("R1 sr", v, exp_sr(0, 0));
    rd(28, v); check("R1 ssr", v, 32'hFFFF_FFFF);
    rd(29, v); check("R1 txocc", v, 0);
    rd(30, v); check("R1 rxocc", v, 0);
    check("R1 pins", {29'd0, sclk, irq, &ss_n}, 32'h1);
    rd(7, v); check("R2 gie", v, 0);

    // random rounds
    for (int r = 0; r < 30; r++) begin
      logic lb, cpol, cpha, man, lsb;
      int nb, cs;
      logic [NSS-1:0] sel;
      lb = 1'($urandom); cpol = 1'($urandom); cpha = 1'($urandom);
      man = 1'($urandom); lsb = 1'($urandom);
      nb = 1 + int'($urandom % 6); cs = int'($urandom % NSS);
      sel = ~(NSS'(1) << cs);
      wr(28, '1);
      m_cpol = cpol; m_cpha = cpha; m_lsb = lsb;
      wr(24, mk_cr(lb, cpol, cpha, man, 0, lsb));
      reset_mon();
      wr(28, 32'(sel));
      for (int i = 0; i < nb; i++) begin
        txb[i] = 8'($urandom); slb[i] = 8'($urandom);
        push_tx(txb[i], slb[i]);
      end
      wait_rx(nb);
      repeat (4) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
        rd(27, v);
        check(lb ? "R9 loopback rx" : "R4 rx byte", v, {24'd0, lb ? txb[i] : slb[i]});
      end
      check("R7 sclk idle", {31'd0, sclk}, {31'd0, cpol});
      check("R10 ss idle", 32'(ss_n), man ? 32'(sel) : 32'hFFFF_FFFF);
      rd(25, v); check("R14 sr drained", v, exp_sr(0, 0));
    end

    // R3 full TX queue drops, R5 inhibit holds
    wr(28, '1);
    m_cpol = 0; m_cpha = 0; m_lsb = 0;
    wr(24, mk_cr(1, 0, 0, 0, 1, 0));
    reset_mon();
    for (int i = 0; i < 17; i++) push_tx(8'(i + 8'h30), 8'h00);
    repeat (60) @(negedge clk);
    rd(29, v); check("R3 tx full drop", v, 16);
    rd(25, v); check("R14 tx full", v, exp_sr(16, 0));
    rd(30, v); check("R5 inhibit idle", v, 0);
    wr(24, mk_cr(1, 0, 0, 0, 0, 0));
    repeat (4) @(negedge clk);
    wr(24, mk_cr(1, 0, 0, 0, 1, 0));
    repeat (80) @(negedge clk);
    rd(30, v); check("R5 byte completes", v, 1);
    rd(29, v); check("R5 rest held", v, 15);
    // R11 TX flush
    wr(24, mk_cr(1, 0, 0, 0, 1, 0) | 32'h20);
    rd(29, v); check("R11 tx flushed", v, 0);
    rd(24, v); check("R11 reset bits read 0", v, mk_cr(1, 0, 0, 0, 1, 0));
    rd(27, v); check("R6 rx byte", v, 32'h30);
    rd(27, v); check("R6 empty read", v, 0);

    // R6 RX full discard
    reset_mon();
    wr(24, mk_cr(1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 16; i++) push_tx(8'(8'hA0 + i), 8'h00);
    wait_rx(16);
    push_tx(8'h11, 8'h00); push_tx(8'h22, 8'h00);
    repeat (120) @(negedge clk);
    rd(30, v); check("R6 rx full discard", v, 16);
    rd(25, v); check("R14 rx full", v, exp_sr(0, 16));
    rd(27, v); check("R6 oldest kept", v, 32'hA0);
    wr(24, mk_cr(1, 0, 0, 0, 0, 0) | 32'h40);
    rd(30, v); check("R11 rx flushed", v, 0);

    // R13 interrupts
    reset_mon();
    wr(10, 3); wr(7, 32'h8000_0000);
    push_tx(8'h5A, 8'h00);
    wait_rx(1);
    repeat (3) @(negedge clk);
    check("R13 irq high", {31'd0, irq}, 1);
    rd(8, v); check("R13 isr", v, 3);
    wr(8, 3);
    repeat (3) @(negedge clk);
    check("R13 irq cleared", {31'd0, irq}, 0);
    rd(8, v); check("R13 isr cleared", v, 0);

    // R12 soft reset key
    wr(28, 32'h0000_FFF0);
    wr(16, 32'h05);
    rd(24, v); check("R12 wrong key ignored", v, mk_cr(1, 0, 0, 0, 0, 0));
    wr(16, 32'h0A);
    rd(24, v); check("R12 cr reset", v, 32'h180);
    rd(28, v); check("R12 ssr reset", v, 32'hFFFF_FFFF);
    rd(10, v); check("R12 ier reset", v, 0);
    rd(30, v); check("R12 rx reset", v, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule